// File: doc/BRIEF.md
# System Control Port with Channel-Check NMI

This block holds an 8-bit system control and status port together with the non-maskable interrupt source that sits behind it. Software writes the lower nibble, which gates timer 2, turns the speaker on and off, and either arms or blocks the channel-check latch. Hardware owns the upper nibble. It reports a refresh toggle driven by timer 1, the timer 2 output level, and a latched channel-check error.

The channel-check input is asynchronous and active low. It passes through a two-stage synchronizer and then an edge detector. A small state machine owns bit 3 (block) and bit 6 (latched). Its states are CK_BLOCKED (bit 3 = 1, bit 6 = 0), CK_ARMED (bit 3 = 0, bit 6 = 0) and CK_LATCHED (bit 3 = 0, bit 6 = 1). It has three transitions:
- The *block* transition goes from any state to CK_BLOCKED when a write sets bit 3.
- The *arm* transition goes from CK_BLOCKED to CK_ARMED when a write clears bit 3.
- The *latch* transition goes from CK_ARMED to CK_LATCHED on a synchronized falling edge.

An NMI pulse one clock wide is produced when an edge is accepted while the NMI mask allows it. A write to the RTC index port sets the NMI mask and passes the index on with its top bit stripped.

Top module: `sysport_nmi`

## Requirements
- R1: After reset the port reads 0x0F, `nmi` is low and the NMI mask is enabled.
- R2: A write changes only port bits 3..0, visible after the next clock edge. Write data bits 7..4 are ignored, and port bit 7 always reads 0.
- R3: `t2_gate` equals port bit 0, and `spkr_n` is the inverse of port bit 1.
- R4: A write with data bit 0 = 0 sets port bit 5 to 1 on the next clock edge.
- R5: Except for the case in R4, port bit 5 takes the new level of `t2_out` one clock after that level changes.
- R6: Port bit 4 inverts one clock after each rising edge of `t1_out`. Holding `t1_out` high or letting it fall causes no further change.
- R7: While port bit 3 is 0, a falling edge on `chk_n` sets port bit 6 on the third clock edge after the falling edge. While bit 3 is 1, such edges are ignored.
- R8: `nmi` pulses in the same cycle that an accepted falling edge is latched, and only if the mask is enabled. It pulses again on later accepted edges while bit 6 stays set.
- R9: A write with data bit 3 = 1 clears port bit 6 on the next edge, and no edge is latched while bit 3 stays 1.
- R10: `nmi` is never high for two consecutive clocks.
- R11: A write to the RTC index port sets the NMI mask to the inverse of data bit 7. `rtc_fwd_data` always equals the index data with bit 7 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Port write strobe, one cycle |
| ctl_wdata | input | 8 | Port write data |
| ctl_rdata | output | 8 | Current port value |
| rtc_idx_wr | input | 1 | RTC index write strobe |
| rtc_idx_data | input | 8 | RTC index write data |
| rtc_fwd_data | output | 8 | Index data passed on to the RTC, bit 7 cleared |
| t1_out | input | 1 | Timer 1 output, synchronous to clk |
| t2_out | input | 1 | Timer 2 output, synchronous to clk |
| chk_n | input | 1 | Asynchronous channel-check error, active low |
| t2_gate | output | 1 | Gate to timer 2 |
| spkr_n | output | 1 | Speaker drive, active low |
| nmi | output | 1 | NMI request, one-clock pulse |

## Verification
The assertions assume three things about the inputs:
- The timer outputs are already synchronous to `clk`.
- Each write strobe lasts one cycle.
- Port writes and RTC index writes never coincide with a channel-check edge reaching the state machine. Without this, the write-wins priority makes the next-state checks ambiguous.

The stimulus changes inputs only on falling clock edges and applies at most one strobe per cycle. Each `chk_n` transition is held for at least three cycles, which is longer than the synchronizer window, before the next change.

// File: rtl/spb_pkg.sv
package spb_pkg;
    localparam int PORT_W = 8;

    typedef enum logic [1:0] {
        CK_BLOCKED = 2'd0,
        CK_ARMED   = 2'd1,
        CK_LATCHED = 2'd2
    } ck_state_e;
endpackage

// File: rtl/spb_sync.sv
module spb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain_q[STAGES-1];
    end

    assign fall = last_q & ~chain_q[STAGES-1];

    // R7: an edge is reported for one cycle only
    p_fall_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/spb_status.sv
module spb_status (
    input  logic clk,
    input  logic rst_n,
    input  logic t1_out,
    input  logic t2_out,
    input  logic wr,
    input  logic wbit0,
    output logic refr_bit,
    output logic t2_bit
);
    logic t1_q, t2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t1_q     <= 1'b0;
            t2_q     <= 1'b0;
            refr_bit <= 1'b0;
            t2_bit   <= 1'b0;
        end else begin
            t1_q <= t1_out;
            t2_q <= t2_out;
            if (t1_out && !t1_q) refr_bit <= ~refr_bit;
            if (wr && !wbit0)       t2_bit <= 1'b1;
            else if (t2_out != t2_q) t2_bit <= t2_out;
        end
    end

    p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wbit0) |=> t2_bit);

    p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_out && !t1_q) |=> (refr_bit != $past(refr_bit)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_out && t1_q) |=> $stable(refr_bit));
endmodule

// File: rtl/spb_chk_fsm.sv
module spb_chk_fsm
    import spb_pkg::*;
#(
    parameter bit RST_BLOCKED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic wr,
    input  logic wbit3,
    input  logic mask_en,
    output logic blocked,
    output logic latched,
    output logic nmi
);
    localparam ck_state_e RST_STATE = RST_BLOCKED ? CK_BLOCKED : CK_ARMED;

    ck_state_e state_q, state_d;
    logic      nmi_d;

    always_comb begin
        state_d = state_q;
        if (wr && wbit3) begin
            state_d = CK_BLOCKED;                   // block
        end else begin
            unique case (state_q)
                CK_BLOCKED: if (wr)   state_d = CK_ARMED;   // arm
                CK_ARMED:   if (fall) state_d = CK_LATCHED; // latch
                CK_LATCHED: state_d = CK_LATCHED;
                default:    state_d = CK_BLOCKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    always_comb begin
        blocked = (state_q == CK_BLOCKED);
        latched = (state_q == CK_LATCHED);
        nmi_d   = fall && (state_q != CK_BLOCKED) && !(wr && wbit3) && mask_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) nmi <= 1'b0;
        else        nmi <= nmi_d;
    end

    p_nmi_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> (state_q == CK_LATCHED));

    p_nmi_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_en |=> !nmi);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wbit3) |=> (state_q == CK_BLOCKED) && !nmi);

    p_nmi_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> !nmi);
endmodule

// File: rtl/sysport_nmi.sv
module sysport_nmi
    import spb_pkg::*;
#(
    parameter logic [3:0] CTL_RESET   = 4'hF,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [PORT_W-1:0] ctl_wdata,
    output logic [PORT_W-1:0] ctl_rdata,
    input  logic              rtc_idx_wr,
    input  logic [PORT_W-1:0] rtc_idx_data,
    output logic [PORT_W-1:0] rtc_fwd_data,
    input  logic              t1_out,
    input  logic              t2_out,
    input  logic              chk_n,
    output logic              t2_gate,
    output logic              spkr_n,
    output logic              nmi
);
    logic [2:0] low_q;
    logic       mask_en_q;
    logic       chk_fall, ck_blocked, ck_latched, refr_bit, t2_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q     <= CTL_RESET[2:0];
            mask_en_q <= 1'b1;
        end else begin
            if (ctl_wr)     low_q     <= ctl_wdata[2:0];
            if (rtc_idx_wr) mask_en_q <= ~rtc_idx_data[7];
        end
    end

    spb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .din (chk_n),
        .fall(chk_fall)
    );

    spb_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .t1_out  (t1_out),
        .t2_out  (t2_out),
        .wr      (ctl_wr),
        .wbit0   (ctl_wdata[0]),
        .refr_bit(refr_bit),
        .t2_bit  (t2_bit)
    );

    spb_chk_fsm #(.RST_BLOCKED(CTL_RESET[3])) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall   (chk_fall),
        .wr     (ctl_wr),
        .wbit3  (ctl_wdata[3]),
        .mask_en(mask_en_q),
        .blocked(ck_blocked),
        .latched(ck_latched),
        .nmi    (nmi)
    );

    assign ctl_rdata    = {1'b0, ck_latched, t2_bit, refr_bit, ck_blocked, low_q};
    assign t2_gate      = low_q[0];
    assign spkr_n       = ~low_q[1];
    assign rtc_fwd_data = {1'b0, rtc_idx_data[6:0]};

    p_wr_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_rdata[3:0] == $past(ctl_wdata[3:0])));

    p_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[7] == 1'b0);

    p_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_idx_wr |=> (mask_en_q == !$past(rtc_idx_data[7])));
endmodule

// File: tb/tb_sysport_nmi.sv
module tb_sysport_nmi;
    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       rtc_idx_wr = 1'b0;
    logic [7:0] rtc_idx_data = 8'h00;
    logic [7:0] rtc_fwd_data;
    logic       t1_out = 1'b0, t2_out = 1'b0, chk_n = 1'b1;
    logic       t2_gate, spkr_n, nmi;

    int  errors = 0, checks = 0;
    bit  done = 1'b0;

    typedef struct {
        logic [7:0] port;
        logic       pulse;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    sysport_nmi dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .rtc_idx_wr(rtc_idx_wr), .rtc_idx_data(rtc_idx_data), .rtc_fwd_data(rtc_fwd_data),
        .t1_out(t1_out), .t2_out(t2_out), .chk_n(chk_n),
        .t2_gate(t2_gate), .spkr_n(spkr_n), .nmi(nmi)
    );

    // Monitor: samples a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (ctl_rdata !== it.port || nmi !== it.pulse ||
                t2_gate !== it.port[0] || spkr_n !== ~it.port[1]) begin
                errors++;
                $display("FAIL %s: port=%h nmi=%b gate=%b spkr_n=%b expected port=%h nmi=%b gate=%b spkr_n=%b",
                         it.tag, ctl_rdata, nmi, t2_gate, spkr_n,
                         it.port, it.pulse, it.port[0], ~it.port[1]);
            end
        end
    end

    // Driver: queues the expected result of the coming edge, then clears strobes
    task automatic tick(input logic [7:0] ep, input logic en, input string tag);
        item_t it;
        it.port = ep; it.pulse = en; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        ctl_wr = 1'b0;
        rtc_idx_wr = 1'b0;
    endtask

    task automatic wr_port(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
    endtask

    task automatic check_fwd(input logic [7:0] exp_v, input string tag);
        #1;
        checks++;
        if (rtc_fwd_data !== exp_v) begin
            errors++;
            $display("FAIL %s: rtc_fwd_data=%h expected %h", tag, rtc_fwd_data, exp_v);
        end
    endtask

    task automatic summary;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        @(negedge clk);
        tick(8'h0F, 1'b0, "R1 reset");
        tick(8'h0F, 1'b0, "R1 reset");
        rst_n = 1'b1;
        tick(8'h0F, 1'b0, "R1 after release");

        // R2 R3: lower nibble write, upper data ignored
        wr_port(8'hF5); tick(8'h05, 1'b0, "R2 upper ignored");
        wr_port(8'h07); tick(8'h07, 1'b0, "R3 speaker on");
        wr_port(8'h05); tick(8'h05, 1'b0, "R3 speaker off");

        // R5: bit 5 follows timer 2
        t2_out = 1'b1; tick(8'h25, 1'b0, "R5 t2 high");
        t2_out = 1'b0; tick(8'h05, 1'b0, "R5 t2 low");

        // R6: refresh toggle on timer 1 rising edges only
        t1_out = 1'b1; tick(8'h15, 1'b0, "R6 rise");
        tick(8'h15, 1'b0, "R6 held");
        t1_out = 1'b0; tick(8'h15, 1'b0, "R6 fall");
        t1_out = 1'b1; tick(8'h05, 1'b0, "R6 second rise");
        t1_out = 1'b0; tick(8'h05, 1'b0, "R6 fall");

        // R4: gate off forces bit 5
        wr_port(8'h06); tick(8'h26, 1'b0, "R4 forced");
        wr_port(8'h05); tick(8'h25, 1'b0, "R4 stays");
        t2_out = 1'b1; tick(8'h25, 1'b0, "R5 t2 high");
        t2_out = 1'b0; tick(8'h05, 1'b0, "R5 t2 low");

        // R7 R8 R10: channel check latch with NMI
        chk_n = 1'b0;
        tick(8'h05, 1'b0, "R7 sync1");
        tick(8'h05, 1'b0, "R7 sync2");
        tick(8'h45, 1'b1, "R7 R8 latch and nmi");
        tick(8'h45, 1'b0, "R10 single pulse");
        chk_n = 1'b1;
        for (int i = 0; i < 3; i++) tick(8'h45, 1'b0, "R7 rising ignored");

        // R9: clear and block
        wr_port(8'h0D); tick(8'h0D, 1'b0, "R9 clear");
        chk_n = 1'b0;
        for (int i = 0; i < 4; i++) tick(8'h0D, 1'b0, "R9 blocked");
        chk_n = 1'b1;
        for (int i = 0; i < 3; i++) tick(8'h0D, 1'b0, "R9 blocked");

        // R11: mask off via RTC index bit 7
        rtc_idx_wr = 1'b1; rtc_idx_data = 8'h80;
        check_fwd(8'h00, "R11 strip bit 7");
        tick(8'h0D, 1'b0, "R11 mask write");
        wr_port(8'h05); tick(8'h05, 1'b0, "R9 rearm");
        chk_n = 1'b0;
        tick(8'h05, 1'b0, "R8 masked");
        tick(8'h05, 1'b0, "R8 masked");
        tick(8'h45, 1'b0, "R8 masked no nmi");
        tick(8'h45, 1'b0, "R8 masked");
        chk_n = 1'b1;
        for (int i = 0; i < 3; i++) tick(8'h45, 1'b0, "R8 idle");

        // R11 R8: unmask, repeat edge while latched
        rtc_idx_wr = 1'b1; rtc_idx_data = 8'h05;
        check_fwd(8'h05, "R11 pass through");
        tick(8'h45, 1'b0, "R11 unmask");
        chk_n = 1'b0;
        tick(8'h45, 1'b0, "R8 repeat");
        tick(8'h45, 1'b0, "R8 repeat");
        tick(8'h45, 1'b1, "R8 repeat nmi");
        tick(8'h45, 1'b0, "R10 single pulse");
        chk_n = 1'b1;
        for (int i = 0; i < 3; i++) tick(8'h45, 1'b0, "R8 idle");

        wr_port(8'hFF); tick(8'h0F, 1'b0, "R2 R9 final");
        tick(8'h0F, 1'b0, "R2 stable");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end
endmodule